// File: doc/BRIEF.md
# Hang-Type Automatic Gain Control with Soft Limiting

This block levels a stream of signed demodulated audio samples so that weak and strong signals come out at a similar loudness. A peak follower keeps a running estimate of the signal magnitude. The estimate climbs quickly when the input grows. When the input falls, the estimate holds still for a programmable number of samples, and only then decays by a programmable fraction per sample.

Each accepted sample triggers a gain calculation, the target level divided by the estimate. A compact non-restoring divider works it out one quotient bit per clock. The sample is then scaled by that gain. The scaled value passes through a two-stage limiter: above a soft threshold the excess is halved, and the result is then clamped to a hard limit.

The audio sample period is far longer than the computation, so the block accepts one sample, spends a fixed number of cycles on it and then pulses its result. Gain has GAIN_FRAC fractional bits.

Top module: `agc_hang_core`

## Requirements
- R1: After reset out_valid and out_data are 0, and both the magnitude estimate and the hang counter are 0.
- R2: When an accepted sample's magnitude |x| is greater than the estimate E, the new estimate is E + ((|x| - E) >> 2) and the hang counter is reloaded with hang_len.
- R3: When |x| is not greater than E and the hang counter is nonzero, E is held and the hang counter decrements by one.
- R4: When |x| is not greater than E and the hang counter is zero, the new estimate is E - (E >> decay_shift).
- R5: The gain is floor(target * 2^GAIN_FRAC / D), where D is the updated estimate, or 1 when that estimate is 0. The gain saturates at GAIN_MAX.
- R6: The scaled magnitude is floor(|x| * gain / 2^GAIN_FRAC), and the output carries the sign of x. An output of 0 is always 0.
- R7: A scaled magnitude M above soft_thr becomes soft_thr + ((M - soft_thr) >> 1).
- R8: After the soft stage the magnitude is clamped to hard_lim.
- R9: out_valid is a one-cycle pulse at exactly DW + GAIN_FRAC + 2 rising edges after the accepting edge, counting that edge as the first. out_data holds its value until the next result.
- R10: An in_valid that arrives while a sample is being processed is ignored. It produces no output and leaves the estimate and hang counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe; accepted only when idle |
| in_data | input | DW | Signed input sample |
| hang_len | input | HW | Hang length in samples, reloaded on attack |
| decay_shift | input | 4 | Decay rate as a right-shift of the estimate |
| target | input | DW | Desired output magnitude (unsigned) |
| soft_thr | input | DW-1 | Soft clipping threshold (unsigned) |
| hard_lim | input | DW-1 | Hard clamp level (unsigned) |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DW | Signed levelled output sample |

## Verification
The hardest behaviour to reach is the hang phase. Seeing it needs an attack that leaves a large estimate, followed by a run of quieter samples. Those samples must count the hang counter down to exactly zero before the first decay step shows up in the gain. A directed sequence builds this: loud samples, then quiet ones with a short hang length. The bench's reference model reproduces the estimate at each step, so the output distinguishes hold from decay sample by sample. Gain saturation and a zero estimate are reached by starting from reset with tiny inputs. A second strobe is injected mid-division to show that it is dropped.

// File: rtl/agc_pkg.sv
package agc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } agc_st_t;
endpackage

// File: rtl/agc_peak_track.sv
module agc_peak_track #(
    parameter int EW = 16,
    parameter int HW = 8
) (
    input  logic [EW-1:0] mag,
    input  logic [EW-1:0] est,
    input  logic [HW-1:0] hang,
    input  logic [HW-1:0] hang_len,
    input  logic [3:0]    decay_shift,
    output logic [EW-1:0] est_nxt,
    output logic [HW-1:0] hang_nxt,
    output logic          attack
);
    logic [EW-1:0] diff;
    logic [EW-1:0] decay_amt;

    always_comb begin
        diff      = mag - est;
        decay_amt = est >> decay_shift;
        attack    = (mag > est);
        est_nxt   = est;
        hang_nxt  = hang;
        if (attack) begin
            est_nxt  = est + (diff >> 2);
            hang_nxt = hang_len;
        end else if (hang != '0) begin
            hang_nxt = hang - 1'b1;
        end else begin
            est_nxt  = est - decay_amt;
        end
    end
endmodule

// File: rtl/agc_nr_div.sv
module agc_nr_div #(
    parameter int NW = 24,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [NW-1:0] quot
);
    localparam int RW = VW + 2;
    localparam int CW = (NW > 1) ? $clog2(NW) : 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [RW-1:0] rem;
        logic [NW-1:0] num;
        logic [NW-1:0] quot;
        logic [VW-1:0] dvs;
    } div_t;

    div_t q, d;
    logic [RW-1:0] shifted;
    logic [RW-1:0] dvs_ext;
    logic [RW-1:0] rem_new;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem[RW-2:0], q.num[NW-1]};
        dvs_ext = {2'b00, q.dvs};
        rem_new = q.rem[RW-1] ? (shifted + dvs_ext) : (shifted - dvs_ext);
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.cnt  = CW'(NW - 1);
                d.rem  = '0;
                d.num  = dividend;
                d.quot = '0;
                d.dvs  = divisor;
            end
        end else begin
            d.rem  = rem_new;
            d.num  = q.num << 1;
            d.quot = {q.quot[NW-2:0], ~rem_new[RW-1]};
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign done = q.done;
    assign quot = q.quot;
endmodule

// File: rtl/agc_limiter.sv
module agc_limiter #(
    parameter int DW = 16,
    parameter int GW = 16,
    parameter int GF = 8
) (
    input  logic [DW-1:0] x,
    input  logic [GW-1:0] gain,
    input  logic [DW-2:0] soft_thr,
    input  logic [DW-2:0] hard_lim,
    output logic [DW-1:0] y
);
    localparam int PW = DW + 1 + GW;

    logic          neg;
    logic [DW:0]   ax;
    logic [PW-1:0] prod;
    logic [PW-1:0] pm;
    logic [PW-1:0] soft_w;
    logic [PW-1:0] sm;
    logic [DW-2:0] hm;
    logic [DW-1:0] hs;

    always_comb begin
        neg    = x[DW-1];
        ax     = neg ? (~{x[DW-1], x} + 1'b1) : {1'b0, x};
        prod   = PW'(ax) * PW'(gain);
        pm     = prod >> GF;
        soft_w = PW'(soft_thr);
        sm     = (pm > soft_w) ? (soft_w + ((pm - soft_w) >> 1)) : pm;
        hm     = (sm > PW'(hard_lim)) ? hard_lim : sm[DW-2:0];
        hs     = {1'b0, hm};
        y      = neg ? (~hs + 1'b1) : hs;
    end
endmodule

// File: rtl/agc_hang_core.sv
module agc_hang_core #(
    parameter int DW        = 16,
    parameter int HW        = 8,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 8,
    parameter int GAIN_MAX  = (1 << 16) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic [HW-1:0] hang_len,
    input  logic [3:0]    decay_shift,
    input  logic [DW-1:0] target,
    input  logic [DW-2:0] soft_thr,
    input  logic [DW-2:0] hard_lim,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    import agc_pkg::*;

    localparam int NW = DW + GAIN_FRAC;
    localparam logic [NW-1:0]     GMAX_N = NW'(GAIN_MAX);
    localparam logic [GAIN_W-1:0] GMAX_G = GAIN_W'(GAIN_MAX);

    typedef struct packed {
        agc_st_t       st;
        logic [DW-1:0] x;
        logic [DW-1:0] est;
        logic [HW-1:0] hang;
        logic          ov;
        logic [DW-1:0] od;
    } core_t;

    core_t q, d;

    logic              accept;
    logic [DW-1:0]     in_mag;
    logic [DW-1:0]     est_nxt;
    logic [HW-1:0]     hang_nxt;
    logic              attack;
    logic [DW-1:0]     divisor;
    logic [NW-1:0]     dividend;
    logic              div_busy;
    logic              div_done;
    logic [NW-1:0]     quot;
    logic [GAIN_W-1:0] gain_sat;
    logic [DW-1:0]     lim_y;
    logic [DW-1:0]     est_q;
    logic [HW-1:0]     hang_q;
    logic              busy_q;

    assign accept   = (q.st == ST_IDLE) && in_valid;
    assign in_mag   = in_data[DW-1] ? (~in_data + 1'b1) : in_data;
    assign divisor  = (est_nxt == '0) ? DW'(1) : est_nxt;
    assign dividend = {target, {GAIN_FRAC{1'b0}}};
    assign gain_sat = (quot > GMAX_N) ? GMAX_G : quot[GAIN_W-1:0];

    agc_peak_track #(.EW(DW), .HW(HW)) u_peak (
        .mag         (in_mag),
        .est         (q.est),
        .hang        (q.hang),
        .hang_len    (hang_len),
        .decay_shift (decay_shift),
        .est_nxt     (est_nxt),
        .hang_nxt    (hang_nxt),
        .attack      (attack)
    );

    agc_nr_div #(.NW(NW), .VW(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .dividend (dividend),
        .divisor  (divisor),
        .busy     (div_busy),
        .done     (div_done),
        .quot     (quot)
    );

    agc_limiter #(.DW(DW), .GW(GAIN_W), .GF(GAIN_FRAC)) u_lim (
        .x        (q.x),
        .gain     (gain_sat),
        .soft_thr (soft_thr),
        .hard_lim (hard_lim),
        .y        (lim_y)
    );

    always_comb begin
        d    = q;
        d.ov = 1'b0;
        if (accept) begin
            d.st   = ST_WAIT;
            d.x    = in_data;
            d.est  = est_nxt;
            d.hang = hang_nxt;
        end else if ((q.st == ST_WAIT) && div_done) begin
            d.st = ST_IDLE;
            d.ov = 1'b1;
            d.od = lim_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign est_q     = q.est;
    assign hang_q    = q.hang;
    assign busy_q    = (q.st == ST_WAIT);
    assign out_valid = q.ov;
    assign out_data  = q.od;
endmodule

// File: rtl/agc_hang_chk.sv
module agc_hang_chk #(
    parameter int DW       = 16,
    parameter int HW       = 8,
    parameter int GAIN_W   = 16,
    parameter int GAIN_MAX = (1 << 16) - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept,
    input logic              busy_q,
    input logic [DW-1:0]     in_mag,
    input logic [DW-1:0]     est_q,
    input logic [HW-1:0]     hang_q,
    input logic [HW-1:0]     hang_len,
    input logic [GAIN_W-1:0] gain_sat,
    input logic              div_done,
    input logic              out_valid,
    input logic [DW-1:0]     out_data,
    input logic [DW-2:0]     hard_lim
);
    logic [DW-1:0] out_mag;
    assign out_mag = out_data[DW-1] ? (~out_data + 1'b1) : out_data;

    // R2: attack raises the estimate and reloads the hang counter
    p_attack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (in_mag > est_q)) |=> (hang_q == $past(hang_len)) && (est_q >= $past(est_q)));

    // R3: hold during hang
    p_hang_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(in_mag > est_q) && (hang_q != '0))
        |=> (est_q == $past(est_q)) && (hang_q == HW'($past(hang_q) - 1'b1)));

    // R4: decay never raises the estimate
    p_decay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(in_mag > est_q) && (hang_q == '0)) |=> (est_q <= $past(est_q)) && (hang_q == '0));

    // R5: gain never exceeds the cap when used
    p_gain_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> (32'(gain_sat) <= 32'(GAIN_MAX)));

    // R8: output magnitude bounded by the hard limit in force
    p_hard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mag <= DW'($past(hard_lim))));

    // R9: single-cycle result strobe
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R10: state frozen while busy
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(est_q) && $stable(hang_q));
endmodule

bind agc_hang_core agc_hang_chk #(
    .DW(DW), .HW(HW), .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .busy_q    (busy_q),
    .in_mag    (in_mag),
    .est_q     (est_q),
    .hang_q    (hang_q),
    .hang_len  (hang_len),
    .gain_sat  (gain_sat),
    .div_done  (div_done),
    .out_valid (out_valid),
    .out_data  (out_data),
    .hard_lim  (hard_lim)
);

// File: tb/sim_agc_hang_core.sv
module sim_agc_hang_core;
    localparam int DW   = 16;
    localparam int HW   = 8;
    localparam int GF   = 8;
    localparam int GMAX = 65535;
    localparam int LAT  = DW + GF + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [HW-1:0] hang_len = '0;
    logic [3:0]    decay_shift = '0;
    logic [DW-1:0] target = '0;
    logic [DW-2:0] soft_thr = '0;
    logic [DW-2:0] hard_lim = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int vecs = 0;
    int errs = 0;
    longint est_m = 0;
    longint hang_m = 0;

    always #4 clk = ~clk;

    agc_hang_core #(.DW(DW), .HW(HW), .GAIN_W(16), .GAIN_FRAC(GF), .GAIN_MAX(GMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .hang_len(hang_len), .decay_shift(decay_shift), .target(target),
        .soft_thr(soft_thr), .hard_lim(hard_lim),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(string tag, longint act, longint exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model: updates estimate per R2-R4 and returns expected output (R5-R8)
    function automatic longint model(longint x);
        longint mag, dv, g, pm;
        mag = (x < 0) ? -x : x;
        if (mag > est_m) begin
            est_m  = est_m + ((mag - est_m) >> 2);
            hang_m = hang_len;
        end else if (hang_m > 0) begin
            hang_m = hang_m - 1;
        end else begin
            est_m = est_m - (est_m >> decay_shift);
        end
        dv = (est_m == 0) ? 1 : est_m;
        g  = (longint'(target) * 256) / dv;
        if (g > GMAX) g = GMAX;
        pm = (mag * g) >> GF;
        if (pm > soft_thr) pm = soft_thr + ((pm - soft_thr) >> 1);
        if (pm > hard_lim) pm = hard_lim;
        return (x < 0) ? -pm : pm;
    endfunction

    // Send one sample; optionally inject a second strobe at cycle inj (R10)
    task automatic send(string tag, longint x, int inj, longint junk);
        longint exp;
        int lat;
        bit seen;
        exp  = model(x);
        lat  = 0;
        seen = 0;
        @(negedge clk);
        in_data  = DW'(x);
        in_valid = 1'b1;
        while (lat < LAT + 20) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            in_valid = (lat == inj);
            if (lat == inj) in_data = DW'(junk);
            if (out_valid) begin
                seen = 1;
                break;
            end
        end
        in_valid = 1'b0;
        if (!seen) begin
            check({tag, " timeout"}, 0, 1);
        end else begin
            check({tag, " data"}, longint'($signed(out_data)), exp);
            check("R9 latency", lat, LAT);
            @(negedge clk);
            check("R9 pulse width", out_valid, 0);
            check("R9 data hold", longint'($signed(out_data)), exp);
        end
    endtask

    task automatic cfg(int hl, int ds, int tg, int st, int hd);
        hang_len    = HW'(hl);
        decay_shift = 4'(ds);
        target      = DW'(tg);
        soft_thr    = (DW-1)'(st);
        hard_lim    = (DW-1)'(hd);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(2024);
        repeat (5) @(negedge clk);
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 out_data after reset", out_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 + R5: zero estimate uses divisor 1, gain saturates
        cfg(3, 2, 8192, 32000, 32767);
        send("R5 zero-estimate saturation", 2, 0, 0);
        send("R6 negative small", -3, 0, 0);

        // R2 attack climb
        send("R2 attack", 8000, 0, 0);
        send("R2 attack", 8000, 0, 0);
        send("R2 attack neg", -12000, 0, 0);
        // R3 hang then R4 decay
        send("R3 hang hold", 1000, 0, 0);
        send("R3 hang hold", -1000, 0, 0);
        send("R3 hang hold", 500, 0, 0);
        send("R4 decay", 500, 0, 0);
        send("R4 decay", -500, 0, 0);
        cfg(0, 0, 8192, 32000, 32767);
        send("R4 decay shift zero", 100, 0, 0);
        send("R6 zero input", 0, 0, 0);

        // R7 / R8 limiter
        cfg(4, 3, 30000, 4000, 6000);
        send("R7 soft clip", 20000, 0, 0);
        send("R8 hard clamp", 30000, 0, 0);
        send("R8 hard clamp min", -32768, 0, 0);

        // R10: strobe during computation is ignored
        cfg(2, 4, 10000, 20000, 30000);
        send("R10 first sample", 5000, 7, 30000);
        begin
            int extra;
            extra = 0;
            repeat (LAT + 10) begin
                @(negedge clk);
                if (out_valid) extra++;
            end
            check("R10 no extra output", extra, 0);
        end
        send("R10 estimate untouched", 5000, 0, 0);

        // Constrained random
        for (int i = 0; i < 300; i++) begin
            int st, hd;
            longint x;
            if (i % 20 == 0) begin
                st = $urandom_range(1000, 20000);
                hd = st + $urandom_range(0, 12000);
                if (hd > 32767) hd = 32767;
                cfg($urandom_range(0, 7), $urandom_range(0, 15),
                    $urandom_range(500, 20000), st, hd);
            end
            x = longint'($signed(16'($urandom)));
            if (i % 7 == 3) x = x >>> $urandom_range(4, 12);
            send("R6 random", x, 0, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vecs++;
        errs++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule